// File: doc/BRIEF.md
# Program Status Word with Banked Saved Copies

This block keeps the 32-bit status word of a processor core: four condition flags at the top, two interrupt mask bits, and a five-bit operating mode at the bottom. Alongside it sit five saved copies, one for each privileged mode. An exception copies the live word into the saved copy of the mode being entered. A return from exception copies the saved copy of the current mode back into the live word.

Software writes the word through an instruction port, either the flags alone or the whole word. The execute stage pushes new flags through a separate port. All writes are masked. Reserved bits never change. The control part is protected from user mode. A mode value outside the legal set is refused, and the block reports each refused write or entry with a one-cycle pulse. The mode, both mask bits and the flags are offered as separate outputs for the rest of the pipeline.

Top module: `psr_bank`

## Requirements
- R1: After reset the word reads 0x000000D3: supervisor mode (10011), IRQ mask (bit 7) and FIQ mask (bit 6) set, flags clear, and `illegal_mode` low. Every saved copy reads 0x000000D3.
- R2: An execute-stage update (`flag_en`) loads `flag_in` into bits 31:28, with bit 3 of `flag_in` as N, bit 2 as Z, bit 1 as C and bit 0 as V. All other bits keep their value, and the result is visible on the next cycle.
- R3: A flag-only write (`wr_en` with `wr_full`=0) loads `wr_data[31:28]` into the flags in any mode. It leaves bits 27:0 unchanged.
- R4: In a privileged mode, a full write (`wr_en` with `wr_full`=1) loads the flags, bit 7, bit 6 and a legal mode from `wr_data`. Reserved bits 27:8 and bit 5 always read zero.
- R5: In user mode (10000), a full write updates only bits 31:28. The control part stays as it was and `illegal_mode` stays low.
- R6: A privileged full write whose mode field is not one of 10000, 10001, 10010, 10011, 10111 or 11011 keeps the old mode. It still applies the flags and mask bits, and it raises `illegal_mode` for exactly the following cycle.
- R7: Exception entry (`exc_en` with a privileged `exc_mode`) stores the current word into the saved copy of `exc_mode`, switches the mode, sets the IRQ mask and keeps the flags. It also sets the FIQ mask only when the target is FIQ (10001), and all of this happens in one cycle.
- R8: Exception entry with a target of user mode or an illegal encoding changes nothing and raises `illegal_mode` for one cycle.
- R9: Exception return (`ret_en`) loads the saved copy of the current mode into the word. In user mode it does nothing.
- R10: `saved_out` shows the saved copy selected by the current mode, and reads zero in user mode.
- R11: Only one operation acts in a given cycle. The priority order is exception entry, then return, then instruction write, then execute-stage flags. In user mode a `ret_en` still claims its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_en | input | 1 | Execute-stage flag update strobe |
| flag_in | input | 4 | New N, Z, C, V flags |
| wr_en | input | 1 | Instruction write strobe |
| wr_full | input | 1 | 1 = whole word, 0 = flags only |
| wr_data | input | 32 | Word to write |
| exc_en | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode of the exception |
| ret_en | input | 1 | Exception return strobe |
| cpsr_out | output | 32 | Live status word |
| saved_out | output | 32 | Saved copy for the current mode |
| mode | output | 5 | Current mode field |
| irq_mask | output | 1 | IRQ disabled when high |
| fiq_mask | output | 1 | FIQ disabled when high |
| flags | output | 4 | N, Z, C, V |
| illegal_mode | output | 1 | One-cycle pulse on a refused mode |

## Verification
A corrupted live word shows on `cpsr_out` and its field outputs one cycle after the operation that produced it. A wrong saved copy stays hidden until the bank is selected. It then shows on `saved_out` as soon as its mode becomes current, and after a return it reaches the live word one cycle later. The bench therefore chains entries and returns across several modes, so that every bank is written and later read back. It also drives conflicting strobes in one cycle, which exposes a wrong priority on the very next cycle.

// File: rtl/psr_bank.sv
module psr_bank #(
  parameter int NBANK = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flag_en,
  input  logic [3:0]  flag_in,
  input  logic        wr_en,
  input  logic        wr_full,
  input  logic [31:0] wr_data,
  input  logic        exc_en,
  input  logic [4:0]  exc_mode,
  input  logic        ret_en,
  output logic [31:0] cpsr_out,
  output logic [31:0] saved_out,
  output logic [4:0]  mode,
  output logic        irq_mask,
  output logic        fiq_mask,
  output logic [3:0]  flags,
  output logic        illegal_mode
);

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam int IW = $clog2(NBANK);
  localparam logic [31:0] RST_WORD = {24'h0, 1'b1, 1'b1, 1'b0, M_SVC};

  function automatic logic legal(input logic [4:0] m);
    return m == M_USR || m == M_FIQ || m == M_IRQ ||
           m == M_SVC || m == M_ABT || m == M_UND;
  endfunction

  function automatic logic [IW-1:0] bank_of(input logic [4:0] m);
    case (m)
      M_IRQ:   return IW'(1);
      M_SVC:   return IW'(2);
      M_ABT:   return IW'(3);
      M_UND:   return IW'(4);
      default: return IW'(0);
    endcase
  endfunction

  logic [31:0] cur, nxt;
  logic [31:0] saved [NBANK];
  logic        ill_q;

  wire is_user    = cur[4:0] == M_USR;
  wire exc_ok     = exc_en && legal(exc_mode) && exc_mode != M_USR;
  wire do_ret     = !exc_en && ret_en && !is_user;
  wire do_wr      = !exc_en && !ret_en && wr_en;
  wire do_flag    = !exc_en && !ret_en && !wr_en && flag_en;
  wire wr_priv    = do_wr && wr_full && !is_user;
  wire wr_mode_ok = legal(wr_data[4:0]);
  wire ill_nxt    = (exc_en && !exc_ok) || (wr_priv && !wr_mode_ok);

  always_comb begin
    nxt = cur;
    if (exc_ok) begin
      nxt[4:0] = exc_mode;
      nxt[7]   = 1'b1;
      if (exc_mode == M_FIQ) nxt[6] = 1'b1;
    end else if (do_ret) begin
      nxt = saved[bank_of(cur[4:0])];
    end else if (do_wr) begin
      nxt[31:28] = wr_data[31:28];
      if (wr_priv) begin
        nxt[7:6] = wr_data[7:6];
        if (wr_mode_ok) nxt[4:0] = wr_data[4:0];
      end
    end else if (do_flag) begin
      nxt[31:28] = flag_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= RST_WORD;
      ill_q <= 1'b0;
    end else begin
      cur   <= nxt;
      ill_q <= ill_nxt;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NBANK; i++) begin
      if (!rst_n)
        saved[i] <= RST_WORD;
      else if (exc_ok && bank_of(exc_mode) == IW'(i))
        saved[i] <= cur;
    end
  end

  assign cpsr_out     = cur;
  assign saved_out    = is_user ? 32'h0 : saved[bank_of(cur[4:0])];
  assign mode         = cur[4:0];
  assign irq_mask     = cur[7];
  assign fiq_mask     = cur[6];
  assign flags        = cur[31:28];
  assign illegal_mode = ill_q;

  a_r2_flag_path: assert property (@(posedge clk) disable iff (!rst_n)
    do_flag |=> flags == $past(flag_in) && cpsr_out[27:0] == $past(cpsr_out[27:0]));

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_out[27:8] == 20'h0 && !cpsr_out[5]);

  a_r5_user_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && is_user) |=> cpsr_out[27:0] == $past(cpsr_out[27:0]) && !illegal_mode);

  a_r6_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    legal(mode));

  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_mode |-> $past(exc_en || (wr_en && wr_full)));

  a_r7_exc_entry: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ok |=> mode == $past(exc_mode) && irq_mask && flags == $past(flags));

  a_r9_ret_user: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !exc_en && is_user) |=> $stable(cpsr_out));

endmodule

// File: tb/test_psr_bank.sv
module test_psr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flag_en = 1'b0;
  logic [3:0]  flag_in = 4'h0;
  logic        wr_en = 1'b0;
  logic        wr_full = 1'b0;
  logic [31:0] wr_data = 32'h0;
  logic        exc_en = 1'b0;
  logic [4:0]  exc_mode = 5'h0;
  logic        ret_en = 1'b0;
  logic [31:0] cpsr_out, saved_out;
  logic [4:0]  mode;
  logic        irq_mask, fiq_mask, illegal_mode;
  logic [3:0]  flags;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  psr_bank i_psr_bank (
    .clk(clk), .rst_n(rst_n), .flag_en(flag_en), .flag_in(flag_in),
    .wr_en(wr_en), .wr_full(wr_full), .wr_data(wr_data),
    .exc_en(exc_en), .exc_mode(exc_mode), .ret_en(ret_en),
    .cpsr_out(cpsr_out), .saved_out(saved_out), .mode(mode),
    .irq_mask(irq_mask), .fiq_mask(fiq_mask), .flags(flags),
    .illegal_mode(illegal_mode)
  );

  // {op, exc target, data, expected word, expected pulse}
  // op: 1 flags from execute, 2 flag-only write, 3 full write, 4 entry, 5 return
  localparam int NV = 20;
  localparam logic [72:0] VEC [NV] = '{
    {3'd1, 5'b00000, 32'h0000000A, 32'hA00000D3, 1'b0}, // R2
    {3'd2, 5'b00000, 32'h5FFFFFFF, 32'h500000D3, 1'b0}, // R3
    {3'd3, 5'b00000, 32'h0FFFFF12, 32'h00000012, 1'b0}, // R4 reserved kept
    {3'd4, 5'b10001, 32'h00000000, 32'h000000D1, 1'b0}, // R7 FIQ sets F
    {3'd1, 5'b00000, 32'h0000000F, 32'hF00000D1, 1'b0}, // R2
    {3'd3, 5'b00000, 32'h20000005, 32'h20000011, 1'b1}, // R6
    {3'd5, 5'b00000, 32'h00000000, 32'h00000012, 1'b0}, // R9
    {3'd3, 5'b00000, 32'hC0000010, 32'hC0000010, 1'b0}, // R4 to user
    {3'd3, 5'b00000, 32'h300000D3, 32'h30000010, 1'b0}, // R5
    {3'd5, 5'b00000, 32'h00000000, 32'h30000010, 1'b0}, // R9 user ignored
    {3'd4, 5'b11011, 32'h00000000, 32'h3000009B, 1'b0}, // R7 F untouched
    {3'd4, 5'b10000, 32'h00000000, 32'h3000009B, 1'b1}, // R8
    {3'd5, 5'b00000, 32'h00000000, 32'h30000010, 1'b0}, // R9
    {3'd4, 5'b10111, 32'h00000000, 32'h30000097, 1'b0}, // R7
    {3'd4, 5'b10011, 32'h00000000, 32'h30000093, 1'b0}, // R7
    {3'd5, 5'b00000, 32'h00000000, 32'h30000097, 1'b0}, // R9
    {3'd5, 5'b00000, 32'h00000000, 32'h30000010, 1'b0}, // R9
    {3'd3, 5'b00000, 32'h00000005, 32'h00000010, 1'b0}, // R5 no pulse
    {3'd4, 5'b10010, 32'h00000000, 32'h00000092, 1'b0}, // R7
    {3'd2, 5'b00000, 32'h80000000, 32'h80000092, 1'b0}  // R3
  };

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4/R5/R6";
      3'd4: return "R7/R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input logic [31:0] exp, input logic ill);
    check32(req, cpsr_out, exp);
    check32(req, {flags, 20'h0, irq_mask, fiq_mask, 1'b0, mode},
            {exp[31:28], 20'h0, exp[7:6], 1'b0, exp[4:0]});
    check32(req, {31'h0, illegal_mode}, {31'h0, ill});
  endtask

  task automatic idle();
    flag_en = 0; wr_en = 0; wr_full = 0; exc_en = 0; ret_en = 0;
    flag_in = 0; wr_data = 0; exc_mode = 0;
  endtask

  task automatic step(input logic [2:0] op, input logic [4:0] tm, input logic [31:0] d);
    @(negedge clk);
    idle();
    case (op)
      3'd1: begin flag_en = 1; flag_in = d[3:0]; end
      3'd2: begin wr_en = 1; wr_data = d; end
      3'd3: begin wr_en = 1; wr_full = 1; wr_data = d; end
      3'd4: begin exc_en = 1; exc_mode = tm; end
      3'd5: ret_en = 1;
      default: ;
    endcase
    @(posedge clk);
    #1 idle();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check_word("R1", 32'h000000D3, 1'b0);
    check32("R1", saved_out, 32'h000000D3);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][72:70], VEC[k][69:65], VEC[k][64:33]);
      check_word(tag(VEC[k][72:70]), VEC[k][32:1], VEC[k][0]);
    end
    // R10 irq bank holds the user word stored by the last entry
    check32("R10", saved_out, 32'h00000010);

    // R11 entry beats write and flags
    @(negedge clk);
    exc_en = 1; exc_mode = 5'b10001; flag_en = 1; flag_in = 4'h0;
    wr_en = 1; wr_full = 1; wr_data = 32'hF000001F;
    @(posedge clk); #1 idle();
    check_word("R11", 32'h800000D1, 1'b0);
    check32("R10", saved_out, 32'h80000092);

    // R11 return beats write
    @(negedge clk);
    ret_en = 1; wr_en = 1; wr_full = 1; wr_data = 32'h00000013;
    @(posedge clk); #1 idle();
    check_word("R11", 32'h80000092, 1'b0);
    check32("R10", saved_out, 32'h00000010);

    // R11 write beats execute flags
    @(negedge clk);
    wr_en = 1; wr_data = 32'h10000000; flag_en = 1; flag_in = 4'hF;
    @(posedge clk); #1 idle();
    check_word("R11", 32'h10000092, 1'b0);

    // R6 pulse lasts one cycle
    step(3'd3, 5'b0, 32'h0000001F);
    check_word("R6", 32'h00000012, 1'b1);
    step(3'd0, 5'b0, 32'h0);
    check_word("R6", 32'h00000012, 1'b0);

    // R10 user mode reads zero
    step(3'd3, 5'b0, 32'h00000010);
    check32("R10", saved_out, 32'h0);

    // R1 reset again mid-run
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    check_word("R1", 32'h000000D3, 1'b0);
    check32("R1", saved_out, 32'h000000D3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule